// File: doc/BRIEF.md
# LIN Slave Response Receiver

This block takes over once a LIN header has been seen. An external bit-level receiver supplies decoded bytes with a valid strobe. It also supplies a break-detected strobe and a sync-complete strobe. After the sync strobe, the next byte is taken as the frame identifier and reported to software. Software decodes the identifier and answers with a single control-byte write. That byte sets the data length, the checksum seed mode and a transmit-go request for a neighbouring transmitter.

Data bytes are stored in an 8-entry receive buffer. Frames longer than the buffer, up to 64 data bytes, are handled by raising a buffer-full flag at each filled chunk. Software drains the buffer by clearing that flag, and reception continues. A final checksum byte is verified against an end-around-carry sum. A break that arrives while bytes are still expected marks the unfinished frame with a framing error.

Top module: `lin_rsp_rx`

## Requirements
- R1: The control byte is laid out as bit 7 = transmit-go, bit 6 = checksum mode, bits 5:0 = data length minus one (lengths 1 to 64). It is accepted only while an identifier awaits its control byte. `respTxGo` follows bit 7 from an accepted write until the next break.
- R2: After `syncDone`, the next valid byte is captured on `frameId`, sets status bit 0 (identifier received) and empties the buffer (`bufLevel` = 0).
- R3: Status bit 0 stays set until an accepted control write or a write-one-to-clear. An accepted control write clears it.
- R4: Data bytes are stored in arrival order at buffer index 0 upward, and `bufLevel` counts them. Bytes that arrive before the control write are stored too.
- R5: The checksum is an 8-bit sum with end-around carry. With mode 1 it is seeded with the identifier; with mode 0 it starts at the first data byte. When the checksum byte follows the last data byte, status bit 2 (frame done) is set. If the sum plus the checksum byte is not 0xFF, status bit 4 (checksum error) is also set.
- R6: When a stored byte brings the buffer to 8 entries and the frame is not yet complete, status bit 1 (buffer full) is set. Writing 1 to status bit 1 empties the buffer and reception continues. A frame that ends exactly on a full buffer does not set bit 1.
- R7: A data byte that arrives while the buffer holds 8 undrained entries is dropped. It is neither stored nor counted nor summed, and it sets status bit 5 (overrun).
- R8: There is no timeout while bytes are expected. A break during the data or checksum phase sets status bit 3 (framing error). The following header is still processed normally and sets status bit 0.
- R9: `irq` is the OR of status bits 0 to 4; bit 5 does not drive it. Writing 1 to a bit of `clrMask` with `clrWr` clears that bit. A flag set in the same cycle wins.
- R10: Bytes outside the identifier, data and checksum windows are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxByte | input | 8 | Decoded received byte |
| rxValid | input | 1 | rxByte valid strobe |
| brkDet | input | 1 | Break detected strobe |
| syncDone | input | 1 | Sync field completed strobe |
| ctlWr | input | 1 | Control byte write strobe |
| ctlData | input | 8 | Control byte value |
| clrWr | input | 1 | Status clear strobe |
| clrMask | input | 6 | Write-one-to-clear status mask |
| bufRdIdx | input | 3 | Buffer read index |
| bufRdData | output | 8 | Buffer entry at bufRdIdx |
| bufLevel | output | 4 | Bytes held in the buffer |
| frameId | output | 8 | Captured identifier byte |
| status | output | 6 | Flag vector (bits as in R2 to R7) |
| irq | output | 1 | Interrupt request |
| respTxGo | output | 1 | Transmit-go request to the transmitter |

## Verification
The hardest situations to reach are a chunk boundary that coincides with the frame end, and a control write that lands after data bytes have already arrived. The bench sweeps every length from 1 to 64 in both checksum modes. At each chunk boundary it drains the buffer and compares the contents, so exact-multiple lengths exercise the no-full-flag case. Dedicated sequences then deliver bytes before the control write, withhold a drain to force an overrun, and cut a frame short with a new break.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_ID, ST_CTL, ST_DATA, ST_CHK
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capId;
    logic pushData;
    logic foldId;
    logic drain;
  } dpCmd_t;

  localparam int F_ID   = 0;
  localparam int F_FULL = 1;
  localparam int F_DONE = 2;
  localparam int F_FRM  = 3;
  localparam int F_CHK  = 4;
  localparam int F_OVR  = 5;
  localparam int FLAG_W = 6;

  function automatic logic [7:0] addCarry(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction

endpackage

// File: rtl/lin_rx_dp.sv
module lin_rx_dp
  import lin_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [7:0]       rxByte,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData,
  output logic [CNT_W-1:0] level,
  output logic [7:0]       idReg,
  output logic             chkPass
);

  logic [7:0]       slot [DEPTH];
  logic [CNT_W-1:0] fillBase;
  logic [7:0]       sumQ;
  logic [7:0]       sumD;

  always_comb fillBase = cmd.drain ? '0 : level;

  always_comb begin
    sumD = sumQ;
    if (cmd.pushData) sumD = addCarry(sumD, rxByte);
    if (cmd.foldId)   sumD = addCarry(sumD, idReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) slot[k] <= '0;
    end else if (cmd.pushData) begin
      slot[IDX_W'(fillBase)] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= '0;
      sumQ  <= '0;
      idReg <= '0;
    end else if (cmd.capId) begin
      level <= '0;
      sumQ  <= '0;
      idReg <= rxByte;
    end else begin
      if (cmd.pushData)   level <= fillBase + 1'b1;
      else if (cmd.drain) level <= '0;
      sumQ <= sumD;
    end
  end

  assign rdData  = slot[rdIdx];
  assign chkPass = (addCarry(sumQ, rxByte) == 8'hFF);

endmodule

// File: rtl/lin_rx_ctrl.sv
module lin_rx_ctrl
  import lin_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int LEN_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              brkDet,
  input  logic              syncDone,
  input  logic              ctlWr,
  input  logic [7:0]        ctlData,
  input  logic              clrWr,
  input  logic [FLAG_W-1:0] clrMask,
  input  logic [CNT_W-1:0]  level,
  input  logic              chkPass,
  output dpCmd_t            cmd,
  output logic [FLAG_W-1:0] flags,
  output logic              irq,
  output logic              respTxGo
);

  rxState_e          state, stateNxt;
  logic [LEN_W:0]    rcvd, rcvdNxt;
  logic [LEN_W-1:0]  lenM1;
  logic [FLAG_W-1:0] setVec, clrVec;
  logic [CNT_W-1:0]  lvlEff;
  logic inResp, byteIn, ctlTake, lastData, fills, chkByte, ovr;

  always_comb begin
    inResp    = (state == ST_CTL) || (state == ST_DATA);
    byteIn    = rxValid && !brkDet;
    ctlTake   = ctlWr && (state == ST_CTL) && !brkDet;
    cmd.drain = clrWr && clrMask[F_FULL];
    lvlEff    = cmd.drain ? '0 : level;
    cmd.capId    = byteIn && (state == ST_ID);
    cmd.pushData = byteIn && inResp && (lvlEff != CNT_W'(DEPTH));
    cmd.foldId   = ctlTake && ctlData[6];
    ovr      = byteIn && inResp && (lvlEff == CNT_W'(DEPTH));
    lastData = cmd.pushData && (state == ST_DATA) && (rcvd == {1'b0, lenM1});
    fills    = cmd.pushData && (lvlEff == CNT_W'(DEPTH - 1)) && !lastData;
    chkByte  = byteIn && (state == ST_CHK);
    rcvdNxt  = rcvd + {{LEN_W{1'b0}}, cmd.pushData};
  end

  always_comb begin
    stateNxt = state;
    if (brkDet) stateNxt = ST_SYNC;
    else begin
      case (state)
        ST_SYNC: if (syncDone) stateNxt = ST_ID;
        ST_ID:   if (cmd.capId) stateNxt = ST_CTL;
        ST_CTL:  if (ctlTake)
                   stateNxt = (rcvdNxt > {1'b0, ctlData[LEN_W-1:0]}) ? ST_CHK : ST_DATA;
        ST_DATA: if (lastData) stateNxt = ST_CHK;
        ST_CHK:  if (chkByte) stateNxt = ST_IDLE;
        default: stateNxt = state;
      endcase
    end
  end

  always_comb begin
    setVec         = '0;
    setVec[F_ID]   = cmd.capId;
    setVec[F_FULL] = fills;
    setVec[F_DONE] = chkByte;
    setVec[F_FRM]  = brkDet && ((state == ST_DATA) || (state == ST_CHK));
    setVec[F_CHK]  = chkByte && !chkPass;
    setVec[F_OVR]  = ovr;
    clrVec         = clrWr ? clrMask : '0;
    if (ctlTake) clrVec[F_ID] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rcvd     <= '0;
      lenM1    <= '0;
      flags    <= '0;
      respTxGo <= 1'b0;
    end else begin
      state <= stateNxt;
      rcvd  <= cmd.capId ? '0 : rcvdNxt;
      flags <= (flags & ~clrVec) | setVec;
      if (ctlTake) lenM1 <= ctlData[LEN_W-1:0];
      if (brkDet)       respTxGo <= 1'b0;
      else if (ctlTake) respTxGo <= ctlData[7];
    end
  end

  assign irq = |flags[F_CHK:F_ID];

endmodule

// File: rtl/lin_rsp_rx.sv
module lin_rsp_rx
  import lin_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  parameter int LEN_W     = 6,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxByte,
  input  logic              rxValid,
  input  logic              brkDet,
  input  logic              syncDone,
  input  logic              ctlWr,
  input  logic [7:0]        ctlData,
  input  logic              clrWr,
  input  logic [FLAG_W-1:0] clrMask,
  input  logic [IDX_W-1:0]  bufRdIdx,
  output logic [7:0]        bufRdData,
  output logic [CNT_W-1:0]  bufLevel,
  output logic [7:0]        frameId,
  output logic [FLAG_W-1:0] status,
  output logic              irq,
  output logic              respTxGo
);

  dpCmd_t dpCmd;
  logic   chkPass;

  lin_rx_ctrl #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .brkDet(brkDet),
    .syncDone(syncDone), .ctlWr(ctlWr), .ctlData(ctlData),
    .clrWr(clrWr), .clrMask(clrMask), .level(bufLevel), .chkPass(chkPass),
    .cmd(dpCmd), .flags(status), .irq(irq), .respTxGo(respTxGo)
  );

  lin_rx_dp #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .rxByte(rxByte), .rdIdx(bufRdIdx),
    .rdData(bufRdData), .level(bufLevel), .idReg(frameId), .chkPass(chkPass)
  );

endmodule

// File: rtl/lin_rx_chk.sv
module lin_rx_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             brkDet,
  input logic [CNT_W-1:0] bufLevel,
  input logic [5:0]       status
);

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufLevel <= CNT_W'(DEPTH));

  // R4
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufLevel > $past(bufLevel)) |-> (bufLevel == $past(bufLevel) + 1'b1));

  // R2
  id_empties_buf_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> (bufLevel == 0));

  // R6
  full_at_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1]) |-> (bufLevel == CNT_W'(DEPTH)));

  // R7
  overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[5]) |-> ($past(bufLevel) == CNT_W'(DEPTH) && bufLevel == CNT_W'(DEPTH)));

  // R8
  framing_after_break_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[3]) |-> $past(brkDet));

endmodule

bind lin_rsp_rx lin_rx_chk #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .brkDet(brkDet), .bufLevel(bufLevel), .status(status)
);

// File: tb/tb_lin_rsp_rx.sv
module tb_lin_rsp_rx;

  logic       clk = 0;
  logic       rstN = 0;
  logic [7:0] rxByte = 0;
  logic       rxValid = 0, brkDet = 0, syncDone = 0, ctlWr = 0, clrWr = 0;
  logic [7:0] ctlData = 0;
  logic [5:0] clrMask = 0;
  logic [2:0] bufRdIdx = 0;
  logic [7:0] bufRdData, frameId;
  logic [3:0] bufLevel;
  logic [5:0] status;
  logic       irq, respTxGo;

  int total = 0;
  int bad = 0;
  logic [7:0] expBuf [8];
  logic [7:0] sum;

  always #10 clk = ~clk;

  lin_rsp_rx dut (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid), .brkDet(brkDet),
    .syncDone(syncDone), .ctlWr(ctlWr), .ctlData(ctlData), .clrWr(clrWr),
    .clrMask(clrMask), .bufRdIdx(bufRdIdx), .bufRdData(bufRdData),
    .bufLevel(bufLevel), .frameId(frameId), .status(status), .irq(irq),
    .respTxGo(respTxGo)
  );

  function automatic logic [7:0] addc(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxByte = b; rxValid = 1;
    @(negedge clk); rxValid = 0;
  endtask

  task automatic header(input logic [7:0] id);
    @(negedge clk); brkDet = 1;
    @(negedge clk); brkDet = 0; syncDone = 1;
    @(negedge clk); syncDone = 0;
    sendByte(id);
  endtask

  task automatic writeCtl(input logic [7:0] v);
    @(negedge clk); ctlData = v; ctlWr = 1;
    @(negedge clk); ctlWr = 0;
  endtask

  task automatic clearFlags(input logic [5:0] m);
    @(negedge clk); clrMask = m; clrWr = 1;
    @(negedge clk); clrWr = 0;
  endtask

  task automatic readCheck(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      bufRdIdx = 3'(k);
      #1;
      check(bufRdData == expBuf[k], tag, bufRdData, expBuf[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(status == 0, "reset status", status, 0);
    check(irq == 0, "reset irq", irq, 0);
    check(bufLevel == 0, "reset level", bufLevel, 0);
    check(respTxGo == 0, "reset txgo", respTxGo, 0);

    // R10: byte and control write while idle are ignored
    sendByte(8'h55);
    check(bufLevel == 0 && status == 0, "R10 idle byte", {bufLevel, status}, 0);
    writeCtl(8'hC0);
    check(respTxGo == 0, "R10/R1 idle ctl write", respTxGo, 0);

    // sweep: every length, both checksum modes
    for (int m = 0; m < 2; m++) begin
      for (int len = 1; len <= 64; len++) begin
        logic [7:0] id;
        id = 8'((len * 5 + m * 17) & 63);
        header(id);
        check(status == 6'h01, "R2 id flag only", status, 1);
        check(frameId == id, "R2 frameId", frameId, id);
        check(irq == 1, "R9 irq on id", irq, 1);
        writeCtl({1'b0, 1'(m), 6'(len - 1)});
        check(status[0] == 0, "R3 ctl clears id", status[0], 0);
        sum = m ? id : 8'h00;
        for (int i = 0; i < len; i++) begin
          logic [7:0] b;
          b = 8'((i * 37 + len * 11 + m * 101 + 7) & 255);
          expBuf[i % 8] = b;
          sum = addc(sum, b);
          sendByte(b);
          if ((i + 1) % 8 == 0 && i + 1 < len) begin
            check(status[1] == 1, "R6 full flag", status[1], 1);
            check(bufLevel == 8, "R4 level at chunk", bufLevel, 8);
            readCheck(8, "R4 chunk data");
            clearFlags(6'h02);
            check(bufLevel == 0, "R6 drain empties", bufLevel, 0);
          end
        end
        check(status[1] == 0, "R6 no full at frame end", status[1], 0);
        check(bufLevel == 4'(((len - 1) % 8) + 1), "R4 final level", bufLevel, ((len - 1) % 8) + 1);
        readCheck(((len - 1) % 8) + 1, "R4 final data");
        sendByte(~sum);
        check(status[2] == 1, "R5 frame done", status[2], 1);
        check(status[4] == 0, "R5 checksum ok", status[4], 0);
        check(status[5] == 0 && status[3] == 0, "R8 no stray error", status, 4);
        clearFlags(6'h3F);
        check(irq == 0, "R9 irq cleared", irq, 0);
      end
    end

    // R5: mode 0 frame answered with an identifier-seeded checksum
    header(8'h21);
    writeCtl(8'h01);
    sendByte(8'h10); sendByte(8'h20);
    sum = addc(addc(8'h21, 8'h10), 8'h20);
    sendByte(~sum);
    check(status[2] == 1 && status[4] == 1, "R5 seed mismatch", status, 6'h14);
    check(irq == 1, "R9 irq on error", irq, 1);
    clearFlags(6'h3F);

    // R4/R3/R1: bytes before control write, txgo set
    header(8'h15);
    sendByte(8'hA1); sendByte(8'hA2);
    check(status[0] == 1, "R3 id held until ctl", status[0], 1);
    check(bufLevel == 2, "R4 early bytes stored", bufLevel, 2);
    writeCtl(8'hC2);
    check(status[0] == 0, "R3 ctl clears id", status[0], 0);
    check(respTxGo == 1, "R1 txgo set", respTxGo, 1);
    sendByte(8'hA3);
    expBuf[0] = 8'hA1; expBuf[1] = 8'hA2; expBuf[2] = 8'hA3;
    readCheck(3, "R4 early order");
    sum = addc(addc(addc(8'h15, 8'hA1), 8'hA2), 8'hA3);
    sendByte(~sum);
    check(status[2] == 1 && status[4] == 0, "R5 early frame ok", status, 4);
    clearFlags(6'h3F);

    // R7: overrun when not drained
    header(8'h30);
    check(respTxGo == 0, "R1 txgo cleared by break", respTxGo, 0);
    writeCtl(8'h0F);
    sum = 0;
    for (int i = 0; i < 8; i++) begin
      expBuf[i] = 8'(8'h40 + i);
      sum = addc(sum, expBuf[i]);
      sendByte(expBuf[i]);
    end
    check(status[1] == 1, "R6 full", status[1], 1);
    sendByte(8'hEE);
    check(status[5] == 1, "R7 overrun flag", status[5], 1);
    check(bufLevel == 8, "R7 level unchanged", bufLevel, 8);
    readCheck(8, "R7 contents kept");
    clearFlags(6'h1F);
    check(irq == 0 && status[5] == 1, "R9 overrun not in irq", irq, 0);
    for (int i = 0; i < 8; i++) begin
      expBuf[i] = 8'(8'h60 + i);
      sum = addc(sum, expBuf[i]);
      sendByte(expBuf[i]);
    end
    check(status[1] == 0, "R6 exact end no full", status[1], 0);
    sendByte(~sum);
    check(status[2] == 1 && status[4] == 0, "R7 dropped byte not summed", status, 6'h24);
    clearFlags(6'h3F);

    // R8: short frame, no timeout, then new break
    header(8'h0A);
    writeCtl(8'h03);
    sendByte(8'h01); sendByte(8'h02);
    repeat (100) @(negedge clk);
    check(status == 0, "R8 no timeout", status, 0);
    header(8'h0B);
    check(status[3] == 1, "R8 framing error", status[3], 1);
    check(status[0] == 1 && frameId == 8'h0B, "R8 new header ok", frameId, 8'h0B);
    check(bufLevel == 0, "R2 buffer emptied", bufLevel, 0);
    writeCtl(8'h00);
    sendByte(8'h33);
    sendByte(~8'h33);
    check(status[2] == 1 && status[4] == 0, "R8 next frame ok", status, 6'h0C);
    clearFlags(6'h3F);
    check(status == 0 && irq == 0, "R9 all cleared", status, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule